// File: doc/BRIEF.md
# CAVLC Residual Block Analyzer

This block takes the quantized residual coefficients of one transform block and turns them into the syntax elements that a CAVLC bit encoder needs. It accepts either a 4x4 block of sixteen coefficients or a 2x2 chroma DC block of four. Coefficients arrive in raster order in one transfer. The block reorders them into scan order and walks that sequence from its high-frequency end, one coefficient per cycle. From this walk it derives the nonzero count, the trailing ones and their signs, the remaining levels, the zero total and the zero runs. It does not select coding tables and it does not form bit codes.

The results leave as a series of tagged elements on a valid/ready stream, and an end-of-block element closes each series. A zero-block flag that comes with the input skips the walk. In that case the block reports a zero count on the very next cycle.

States: `ST_IDLE` (ready for a block), `ST_SCAN` (reverse walk), and the emit states `ST_TOTAL`, `ST_TRAIL`, `ST_SIGN`, `ST_LEVEL`, `ST_TZEROS`, `ST_RUN`, `ST_EOB`.

Transitions:
- `ST_IDLE` goes to `ST_SCAN` when a block is accepted, or to `ST_TOTAL` when the block is accepted with the zero flag set.
- `ST_SCAN` goes to `ST_TOTAL` after the lowest position has been walked.
- `ST_TOTAL` goes to `ST_EOB` when the count is zero, and to `ST_TRAIL` otherwise.
- `ST_TRAIL` goes to `ST_SIGN`, `ST_LEVEL`, `ST_TZEROS` or `ST_EOB`, skipping every list that is empty.
- `ST_SIGN` and `ST_LEVEL` stay in place until their last item has been taken.
- The zero total follows only when the block is not full.
- `ST_TZEROS` goes to `ST_RUN` when there are zeros and more than one nonzero, and to `ST_EOB` otherwise.
- `ST_RUN` goes to `ST_EOB` when the run list is exhausted or no zeros remain.
- `ST_EOB` goes to `ST_IDLE` once the end element has been taken.

An element moves only on a cycle where both `out_valid` and `out_ready` are high.

Top module: `cavlc_block_analyzer`

## Requirements
- R1: For a 4x4 block, input coefficient k sits at bits [16k+15:16k], and the scan visits raster positions 0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15. For a 2x2 DC block (`in_dc_mode`=1), positions 0..3 are scanned in raster order and positions 4..15 are ignored.
- R2: Each block produces the elements in this order, with these tag codes: count (0), trailing-one count (1), signs (2), levels (3), zero total (4), runs (5), end of block (6). The end element carries value 0 and is always the last element.
- R3: The trailing-one count covers up to three coefficients of value +1 or -1 at the high-frequency end of the nonzero list, and zeros between them are allowed. A further coefficient of magnitude 1 is treated as a level.
- R4: There is one sign element per trailing one, highest frequency first. The value is 1 for a negative coefficient and 0 for a positive one.
- R5: Level elements carry the signed values of the other nonzero coefficients, highest frequency first.
- R6: The zero-total element is sent only when the count is above 0 and below the block size. Its value is the number of zeros that lie before the last nonzero coefficient in scan order.
- R7: Run elements carry, highest frequency first, the number of zeros directly below each nonzero coefficient. There is none for the lowest nonzero coefficient, and the runs stop once the zeros not yet assigned reach 0.
- R8: A block accepted with `in_zero_blk`=1 shows a count element of value 0 on the cycle after acceptance, whatever the coefficients are. Only the end element follows it.
- R9: An all-zero block accepted without the flag produces only a count of 0 and the end element.
- R10: `in_ready` is high only when no element of the previous block is pending. An element that is not taken holds its tag and value.
- R11: Under reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Block offered |
| in_ready | output | 1 | Block accepted when high together with in_valid |
| in_coeffs | input | 256 | Sixteen signed coefficients in raster order |
| in_dc_mode | input | 1 | 1 selects the four-coefficient DC block |
| in_zero_blk | input | 1 | Block is known to be all zero |
| out_valid | output | 1 | Element present |
| out_ready | input | 1 | Element taken when high together with out_valid |
| out_tag | output | 3 | Element kind, coded as in R2 |
| out_value | output | 16 | Element value; counts are zero-extended, levels are signed |

## Verification
Two pairs of conditions can meet in one cycle.

The first pair is in `ST_RUN`. The run list can run out of entries in the same cycle that the zero budget falls to zero. This happens when the lowest nonzero coefficient sits at scan position 0. Directed blocks place it there to provoke the case, and the element list is compared against a bench model to judge it.

The second pair is a stall and a state change. The output stall from a low `out_ready` can coincide with the cycle that would otherwise advance the state. Random `out_ready` patterns provoke this, and the bench checks that a held element keeps its tag and value.

// File: rtl/cavlc_an_pkg.sv
package cavlc_an_pkg;
    localparam int MAXC  = 16;
    localparam int DC_N  = 4;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int IDX_W = $clog2(MAXC);

    typedef enum logic [2:0] {
        TAG_TOTAL  = 3'd0,
        TAG_TRAIL  = 3'd1,
        TAG_SIGN   = 3'd2,
        TAG_LEVEL  = 3'd3,
        TAG_TZEROS = 3'd4,
        TAG_RUN    = 3'd5,
        TAG_EOB    = 3'd6
    } elem_tag_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SCAN, ST_TOTAL, ST_TRAIL, ST_SIGN,
        ST_LEVEL, ST_TZEROS, ST_RUN, ST_EOB
    } an_state_t;

    // scan position -> raster position for the 4x4 block
    function automatic logic [IDX_W-1:0] scan_to_raster(input logic [IDX_W-1:0] k);
        logic [IDX_W-1:0] r;
        case (k)
            4'd0:  r = 4'd0;
            4'd1:  r = 4'd1;
            4'd2:  r = 4'd4;
            4'd3:  r = 4'd8;
            4'd4:  r = 4'd5;
            4'd5:  r = 4'd2;
            4'd6:  r = 4'd3;
            4'd7:  r = 4'd6;
            4'd8:  r = 4'd9;
            4'd9:  r = 4'd12;
            4'd10: r = 4'd13;
            4'd11: r = 4'd10;
            4'd12: r = 4'd7;
            4'd13: r = 4'd11;
            4'd14: r = 4'd14;
            default: r = 4'd15;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cavlc_zz_reorder.sv
module cavlc_zz_reorder
    import cavlc_an_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic [MAXC*COEF_W-1:0] raster_i,
    input  logic                   dc_mode_i,
    output logic [MAXC*COEF_W-1:0] scan_o
);
    for (genvar g = 0; g < MAXC; g++) begin : g_pos
        localparam logic [IDX_W-1:0] RPOS = scan_to_raster(IDX_W'(g));
        if (g < DC_N) begin : g_low
            assign scan_o[g*COEF_W +: COEF_W] = dc_mode_i ? raster_i[g*COEF_W +: COEF_W]
                                                          : raster_i[int'(RPOS)*COEF_W +: COEF_W];
        end else begin : g_high
            assign scan_o[g*COEF_W +: COEF_W] = dc_mode_i ? '0
                                                          : raster_i[int'(RPOS)*COEF_W +: COEF_W];
        end
    end
endmodule

// File: rtl/cavlc_elem_store.sv
module cavlc_elem_store
    import cavlc_an_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_we,
    input  logic [IDX_W-1:0]  lvl_waddr,
    input  logic [COEF_W-1:0] lvl_wdata,
    input  logic              run_we,
    input  logic [IDX_W-1:0]  run_waddr,
    input  logic [CNT_W-1:0]  run_wdata,
    input  logic [IDX_W-1:0]  lvl_raddr,
    input  logic [IDX_W-1:0]  run_raddr,
    output logic [COEF_W-1:0] lvl_rdata,
    output logic [CNT_W-1:0]  run_rdata
);
    logic [COEF_W-1:0] lvl_mem [MAXC];
    logic [CNT_W-1:0]  run_mem [MAXC];

    for (genvar e = 0; e < MAXC; e++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_mem[e] <= '0;
                run_mem[e] <= '0;
            end else begin
                if (lvl_we && lvl_waddr == IDX_W'(e)) lvl_mem[e] <= lvl_wdata;
                if (run_we && run_waddr == IDX_W'(e)) run_mem[e] <= run_wdata;
            end
        end
    end

    assign lvl_rdata = lvl_mem[lvl_raddr];
    assign run_rdata = run_mem[run_raddr];
endmodule

// File: rtl/cavlc_block_analyzer.sv
module cavlc_block_analyzer
    import cavlc_an_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [MAXC*COEF_W-1:0] in_coeffs,
    input  logic                   in_dc_mode,
    input  logic                   in_zero_blk,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [2:0]             out_tag,
    output logic [COEF_W-1:0]      out_value
);
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);
    localparam logic [IDX_W-1:0] I_ONE = IDX_W'(1);
    localparam logic signed [COEF_W-1:0] V_POS1 = COEF_W'(1);
    localparam logic signed [COEF_W-1:0] V_NEG1 = -COEF_W'(1);

    an_state_t st_q, st_d;

    logic [MAXC*COEF_W-1:0] zz_in, zz_q;
    logic [CNT_W-1:0] blk_n_q, tot_q, tz_q, zrun_q, nlev_q, emit_k_q, zl_q;
    logic [1:0]       t1_q;
    logic             t1_open_q, seen_q;
    logic [3:0]       sgn_q;
    logic [IDX_W-1:0] scan_idx_q;

    logic signed [COEF_W-1:0] cur;
    logic nz, take_t1, fire, accept;
    logic [COEF_W-1:0] lvl_rd;
    logic [CNT_W-1:0]  run_rd, t1_ext;
    an_state_t after_lvl;

    cavlc_zz_reorder #(.COEF_W(COEF_W)) u_zz (
        .raster_i  (in_coeffs),
        .dc_mode_i (in_dc_mode),
        .scan_o    (zz_in)
    );

    cavlc_elem_store #(.COEF_W(COEF_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_we    (st_q == ST_SCAN && nz && !take_t1),
        .lvl_waddr (IDX_W'(nlev_q)),
        .lvl_wdata (cur),
        .run_we    (st_q == ST_SCAN && nz && seen_q),
        .run_waddr (IDX_W'(tot_q - C_ONE)),
        .run_wdata (zrun_q),
        .lvl_raddr (IDX_W'(emit_k_q)),
        .run_raddr (IDX_W'(emit_k_q)),
        .lvl_rdata (lvl_rd),
        .run_rdata (run_rd)
    );

    // scan-step decode
    assign cur     = zz_q[int'(scan_idx_q)*COEF_W +: COEF_W];
    assign nz      = (cur != '0);
    assign take_t1 = nz && t1_open_q && (t1_q < 2'd3) && (cur == V_POS1 || cur == V_NEG1);
    assign accept  = in_valid && in_ready;
    assign fire    = out_valid && out_ready;
    assign t1_ext  = CNT_W'(t1_q);
    assign after_lvl = (tot_q < blk_n_q) ? ST_TZEROS : ST_EOB;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (accept) st_d = in_zero_blk ? ST_TOTAL : ST_SCAN;
            ST_SCAN:   if (scan_idx_q == '0) st_d = ST_TOTAL;
            ST_TOTAL:  if (fire) st_d = (tot_q == '0) ? ST_EOB : ST_TRAIL;
            ST_TRAIL:  if (fire) begin
                           if (t1_q != 2'd0)        st_d = ST_SIGN;
                           else if (nlev_q != '0)   st_d = ST_LEVEL;
                           else                     st_d = after_lvl;
                       end
            ST_SIGN:   if (fire && emit_k_q == t1_ext - C_ONE)
                           st_d = (nlev_q != '0) ? ST_LEVEL : after_lvl;
            ST_LEVEL:  if (fire && emit_k_q == nlev_q - C_ONE) st_d = after_lvl;
            ST_TZEROS: if (fire) st_d = (tz_q != '0 && tot_q > C_ONE) ? ST_RUN : ST_EOB;
            ST_RUN:    if (fire && (emit_k_q == tot_q - C_TWO || zl_q == run_rd)) st_d = ST_EOB;
            ST_EOB:    if (fire) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // scan and emit bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zz_q       <= '0;
            blk_n_q    <= '0;
            scan_idx_q <= '0;
            tot_q      <= '0;
            t1_q       <= '0;
            t1_open_q  <= 1'b1;
            seen_q     <= 1'b0;
            tz_q       <= '0;
            zrun_q     <= '0;
            nlev_q     <= '0;
            sgn_q      <= '0;
            emit_k_q   <= '0;
            zl_q       <= '0;
        end else begin
            if (accept) begin
                zz_q       <= zz_in;
                blk_n_q    <= in_dc_mode ? CNT_W'(DC_N) : CNT_W'(MAXC);
                scan_idx_q <= in_dc_mode ? IDX_W'(DC_N - 1) : IDX_W'(MAXC - 1);
                tot_q      <= '0;
                t1_q       <= '0;
                t1_open_q  <= 1'b1;
                seen_q     <= 1'b0;
                tz_q       <= '0;
                zrun_q     <= '0;
                nlev_q     <= '0;
                sgn_q      <= '0;
            end else if (st_q == ST_SCAN) begin
                scan_idx_q <= scan_idx_q - I_ONE;
                if (nz) begin
                    tot_q  <= tot_q + C_ONE;
                    seen_q <= 1'b1;
                    zrun_q <= '0;
                    if (take_t1) begin
                        sgn_q[t1_q] <= cur[COEF_W-1];
                        t1_q        <= t1_q + 2'd1;
                    end else begin
                        t1_open_q <= 1'b0;
                        nlev_q    <= nlev_q + C_ONE;
                    end
                end else if (seen_q) begin
                    tz_q   <= tz_q + C_ONE;
                    zrun_q <= zrun_q + C_ONE;
                end
            end

            if (st_d != st_q)  emit_k_q <= '0;
            else if (fire)     emit_k_q <= emit_k_q + C_ONE;

            if (st_q == ST_TZEROS && fire)  zl_q <= tz_q;
            else if (st_q == ST_RUN && fire) zl_q <= zl_q - run_rd;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (st_q == ST_IDLE);
        out_valid = 1'b0;
        out_tag   = TAG_EOB;
        out_value = '0;
        unique case (st_q)
            ST_IDLE, ST_SCAN: begin
                out_valid = 1'b0;
            end
            ST_TOTAL: begin
                out_valid = 1'b1;
                out_tag   = TAG_TOTAL;
                out_value = COEF_W'(tot_q);
            end
            ST_TRAIL: begin
                out_valid = 1'b1;
                out_tag   = TAG_TRAIL;
                out_value = COEF_W'(t1_q);
            end
            ST_SIGN: begin
                out_valid = 1'b1;
                out_tag   = TAG_SIGN;
                out_value = COEF_W'(sgn_q[emit_k_q[1:0]]);
            end
            ST_LEVEL: begin
                out_valid = 1'b1;
                out_tag   = TAG_LEVEL;
                out_value = lvl_rd;
            end
            ST_TZEROS: begin
                out_valid = 1'b1;
                out_tag   = TAG_TZEROS;
                out_value = COEF_W'(tz_q);
            end
            ST_RUN: begin
                out_valid = 1'b1;
                out_tag   = TAG_RUN;
                out_value = COEF_W'(run_rd);
            end
            ST_EOB: begin
                out_valid = 1'b1;
                out_tag   = TAG_EOB;
            end
            default: out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/cavlc_an_checker.sv
module cavlc_an_checker #(
    parameter int COEF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_zero_blk,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_tag,
    input logic [COEF_W-1:0] out_value
);
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_value)));

    a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r8_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_zero_blk) |=> (out_valid && out_tag == 3'd0 && out_value == '0));

    a_r2_eob_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_tag == 3'd6) |=> in_ready);

    a_r3_trail_max: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 3'd1) |-> (out_value <= COEF_W'(3)));

    a_r4_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 3'd2) |-> (out_value <= COEF_W'(1)));

    a_r6_tz_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 3'd4) |-> (out_value <= COEF_W'(15)));
endmodule

bind cavlc_block_analyzer cavlc_an_checker #(.COEF_W(COEF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_zero_blk (in_zero_blk),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_tag     (out_tag),
    .out_value   (out_value)
);

// File: tb/tb_cavlc_block_analyzer.sv
module tb_cavlc_block_analyzer;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [16*W-1:0] in_coeffs = '0;
    logic in_dc_mode = 1'b0;
    logic in_zero_blk = 1'b0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [2:0] out_tag;
    logic [W-1:0] out_value;

    int checks = 0;
    int errors = 0;
    int exp_tag [64];
    int exp_val [64];
    int exp_n;
    int SCAN [16] = '{0, 1, 4, 8, 5, 2, 3, 6, 9, 12, 13, 10, 7, 11, 14, 15};

    always #5 clk = ~clk;

    cavlc_block_analyzer #(.COEF_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_coeffs(in_coeffs), .in_dc_mode(in_dc_mode), .in_zero_blk(in_zero_blk),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_value(out_value)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic string tag_req(input int t);
        case (t)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic push(input int t, input int v);
        exp_tag[exp_n] = t;
        exp_val[exp_n] = v;
        exp_n++;
    endtask

    task automatic build_exp(input int c [16], input bit dc, input bit zb);
        int n, tot, t1, tz, zl;
        int seq [16];
        int pos [16];
        int v [16];
        exp_n = 0;
        if (zb) begin
            push(0, 0);
            push(6, 0);
            return;
        end
        n = dc ? 4 : 16;
        for (int i = 0; i < n; i++) seq[i] = dc ? c[i] : c[SCAN[i]];
        tot = 0;
        for (int i = 0; i < n; i++)
            if (seq[i] != 0) begin
                pos[tot] = i;
                v[tot] = seq[i];
                tot++;
            end
        push(0, tot);
        if (tot == 0) begin
            push(6, 0);
            return;
        end
        t1 = 0;
        while (t1 < 3 && t1 < tot && (v[tot-1-t1] == 1 || v[tot-1-t1] == -1)) t1++;
        push(1, t1);
        for (int j = 0; j < t1; j++) push(2, (v[tot-1-j] < 0) ? 1 : 0);
        for (int j = tot - 1 - t1; j >= 0; j--) push(3, v[j]);
        if (tot < n) begin
            tz = pos[tot-1] + 1 - tot;
            push(4, tz);
            zl = tz;
            for (int j = tot - 1; j >= 1 && zl > 0; j--) begin
                push(5, pos[j] - pos[j-1] - 1);
                zl -= pos[j] - pos[j-1] - 1;
            end
        end
        push(6, 0);
    endtask

    task automatic run_block(input int c [16], input bit dc, input bit zb, input string lbl);
        int got;
        bit done, prev_stall;
        int prev_tag, prev_val;
        build_exp(c, dc, zb);
        @(negedge clk);
        out_ready = 1'b0;
        for (int i = 0; i < 16; i++) in_coeffs[i*W +: W] = W'(c[i]);
        in_dc_mode = dc;
        in_zero_blk = zb;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_coeffs = {16{16'h0055}};
        #1;
        if (zb)
            check(out_valid && out_tag == 3'd0 && out_value == '0, "R8",
                  {lbl, " count on cycle after accept"}, int'(out_value) + (out_valid ? 0 : 1000), 0);
        got = 0;
        done = 1'b0;
        prev_stall = 1'b0;
        prev_tag = 0;
        prev_val = 0;
        for (int it = 0; it < 400 && !done; it++) begin
            out_ready = ($urandom % 4) != 0;
            #1;
            if (prev_stall) begin
                check(out_valid && int'(out_tag) == prev_tag, "R10", {lbl, " held tag"}, int'(out_tag), prev_tag);
                check(int'($signed(out_value)) == prev_val, "R10", {lbl, " held value"},
                      int'($signed(out_value)), prev_val);
            end
            if (out_valid) check(!in_ready, "R10", {lbl, " in_ready while busy"}, int'(in_ready), 0);
            if (out_valid && out_ready) begin
                if (got < exp_n) begin
                    check(int'(out_tag) == exp_tag[got], tag_req(exp_tag[got]), {lbl, " tag"},
                          int'(out_tag), exp_tag[got]);
                    check(int'($signed(out_value)) == exp_val[got], tag_req(exp_tag[got]), {lbl, " value"},
                          int'($signed(out_value)), exp_val[got]);
                end
                got++;
                if (out_tag == 3'd6) done = 1'b1;
            end
            prev_stall = out_valid && !out_ready;
            prev_tag = int'(out_tag);
            prev_val = int'($signed(out_value));
            if (!done) @(negedge clk);
        end
        check(got == exp_n, "R2", {lbl, " element count"}, got, exp_n);
    endtask

    task automatic gen_random(output int c [16]);
        int sparse;
        sparse = $urandom % 3;
        for (int i = 0; i < 16; i++) begin
            int r;
            r = $urandom % 8;
            if (r < 3 + sparse * 2) c[i] = 0;
            else if (r < 7)         c[i] = ($urandom % 2) ? 1 : -1;
            else                    c[i] = int'($urandom % 81) - 40;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int c [16];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R11", "in_ready under reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R11", "out_valid under reset", int'(out_valid), 0);
        rst_n = 1'b1;

        c = '{default: 0};
        run_block(c, 1'b0, 1'b0, "R9 all-zero");
        c = '{3, 0, -1, 0, 7, 0, 0, 1, 0, 0, 2, 0, 0, 0, 0, 9};
        run_block(c, 1'b0, 1'b1, "R8 flagged");
        c = '{default: 0};
        c[0] = 5; c[7] = 1; c[11] = -1; c[14] = 1; c[15] = -1;
        run_block(c, 1'b0, 1'b0, "R3 fourth one");
        for (int i = 0; i < 16; i++) c[i] = (i % 2 == 0) ? i + 2 : -(i + 2);
        run_block(c, 1'b0, 1'b0, "R1 R6 full");
        c = '{default: 0};
        c[0] = -3;
        run_block(c, 1'b0, 1'b0, "R7 dc only");
        c = '{default: 0};
        c[0] = 2; c[2] = 1; c[12] = -7;
        run_block(c, 1'b0, 1'b0, "R7 both stops");
        c = '{default: 9};
        c[0] = 0; c[1] = 1; c[2] = 0; c[3] = -2;
        run_block(c, 1'b1, 1'b0, "R1 dc garbage");
        c = '{default: 0};
        c[15] = 1;
        run_block(c, 1'b0, 1'b0, "R6 last only");
        c = '{default: 0};
        c[0] = 4; c[1] = -1; c[4] = 6; c[13] = 1;
        run_block(c, 1'b0, 1'b0, "R7 early stop");
        c = '{default: 0};
        c[1] = 1; c[2] = 1; c[3] = -1;
        run_block(c, 1'b1, 1'b0, "R4 dc ones");

        for (int b = 0; b < 300; b++) begin
            bit dc, zb;
            gen_random(c);
            dc = ($urandom % 4) == 0;
            zb = ($urandom % 10) == 0;
            run_block(c, dc, zb, "random");
        end

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule